// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the order of column addresses for one read or write burst of a double-data-rate SDRAM-style memory. A one-cycle start strobe carries a starting column address, a 2-bit burst length code and a burst order select. The block stores these values. From the next clock it puts out one column address per cycle until the burst holds the requested number of beats. A valid flag marks each beat and a last flag marks the final one.

The burst covers an aligned block of 2, 4 or 8 columns. Column bits above the within-block field select that block and stay fixed for the whole burst. Only the low field moves. In sequential order it counts upward from the start index and wraps inside the block. In interleaved order it is the start index XOR the beat number. Both orders are chosen at run time.

A parameter sets what happens when a start arrives while a burst is still running. The block either ignores it or drops the running burst and begins the new one. A length code with no defined meaning produces no beats and raises a one-cycle error flag.

Top module: `burst_col_seq`

## Requirements
- R1: The length code `len_code_i` selects the burst length: 2'b01 gives 2 beats, 2'b10 gives 4 beats and 2'b11 gives 8 beats. The beats come one per clock, starting in the cycle after the start is accepted. `valid_o` is high on exactly those beats.
- R2: On every beat, the `col_o` bits above the within-block field equal those bits of the start column. The within-block field is bit 0 for 2 beats, bits 1:0 for 4 beats and bits 2:0 for 8 beats.
- R3: With `order_i` = 0 (sequential), beat k carries the within-block index (start index + k) modulo the burst length. Example: 4 beats from index 1 give 1,2,3,0.
- R4: With `order_i` = 1 (interleaved), beat k carries the within-block index (start index XOR k). Example: 8 beats from index 5 give 5,4,7,6,1,0,3,2.
- R5: `last_o` is high only on the final beat. In the cycle after the final beat, `valid_o` is low unless a new burst was accepted on that final beat.
- R6: A start is accepted when no burst is running, or on the final beat of a running burst. In the second case the new burst follows with no idle cycle.
- R7: With RESTART_ON_START = 0, a start on any beat other than the final one is ignored and the running burst continues unchanged. With RESTART_ON_START = 1, such a start ends the running burst, and beat 0 of the new burst appears in the next cycle.
- R8: An accepted start with the reserved length code 2'b00 issues no beats. In the next cycle it drives `err_o` high for exactly one cycle, with `valid_o` low.
- R9: Synchronous active-high reset ends any burst. After reset, `valid_o`, `last_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | COL_W | Starting column address |
| len_code_i | input | 2 | Burst length code (01=2, 10=4, 11=8, 00 reserved) |
| order_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final beat |
| err_o | output | 1 | One-cycle pulse after a start with the reserved length code |

## Verification
Assertions check the following on every cycle:
- the block bits stay stable between beats of one burst;
- a sequential burst steps its index by one modulo the length;
- valid falls after a last beat that has no new start;
- an error pulse is always traced to a reserved-code start, and never comes with a valid beat;
- in ignore mode a mid-burst start never breaks the burst.

Some behaviour only the bench scenarios can show:
- the complete address order for each length, order and start index, including wrap at the top of the address range;
- gapless back-to-back bursts;
- the different reaction of the two parameter settings to the same mid-burst start;
- abort on reset.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Widest burst is 8 beats, so the within-block field is 3 bits
    localparam int unsigned IDX_W = 3;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        LEN_RSVD = 2'b00,
        LEN_2    = 2'b01,
        LEN_4    = 2'b10,
        LEN_8    = 2'b11
    } len_code_e;

    // Within-block mask, which is also the number of beats minus one
    function automatic logic [IDX_W-1:0] len_to_mask(input len_code_e code);
        case (code)
            LEN_2:   return 3'd1;
            LEN_4:   return 3'd3;
            LEN_8:   return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

    // Within-block index of beat k, before masking
    function automatic logic [IDX_W-1:0] beat_index(
        input logic [IDX_W-1:0] start_idx,
        input logic [IDX_W-1:0] k,
        input order_e           ord
    );
        if (ord == ORD_INTLV) return start_idx ^ k;
        return start_idx + k;
    endfunction

endpackage

// File: rtl/bseq_len_decode.sv
module bseq_len_decode
    import burst_seq_pkg::*;
(
    input  logic [1:0]       len_code_i,
    output logic [IDX_W-1:0] mask_o,
    output logic             rsvd_o
);
    len_code_e code;

    always_comb begin
        code   = len_code_e'(len_code_i);
        mask_o = len_to_mask(code);
        rsvd_o = (code == LEN_RSVD);
    end
endmodule

// File: rtl/bseq_beat_ctrl.sv
module bseq_beat_ctrl
    import burst_seq_pkg::*;
#(
    parameter bit RESTART_ON_START = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             rsvd_i,
    input  logic [IDX_W-1:0] mask_i,
    output logic             load_o,
    output logic             busy_o,
    output logic             last_o,
    output logic [IDX_W-1:0] beat_o,
    output logic [IDX_W-1:0] lim_o,
    output logic             err_o
);
    logic             busy_q;
    logic [IDX_W-1:0] beat_q;
    logic [IDX_W-1:0] lim_q;
    logic             err_q;
    logic             at_last;

    always_comb begin
        at_last = busy_q && (beat_q == lim_q);
        load_o  = start_i && (!busy_q || at_last || RESTART_ON_START);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            beat_q <= '0;
            lim_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= load_o && rsvd_i;
            if (load_o) begin
                busy_q <= !rsvd_i;
                beat_q <= '0;
                lim_q  <= mask_i;
            end else if (busy_q) begin
                if (at_last) busy_q <= 1'b0;
                else         beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign busy_o = busy_q;
    assign last_o = at_last;
    assign beat_o = beat_q;
    assign lim_o  = lim_q;
    assign err_o  = err_q;

    // R5
    last_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (at_last && !start_i) |=> !busy_q);

    // R8
    err_without_beat_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !busy_q);

    generate
        if (!RESTART_ON_START) begin : g_ignore_chk
            // R7
            mid_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
                (busy_q && !at_last && start_i) |=> (busy_q && beat_q == $past(beat_q) + 1'b1));
        end
    endgenerate
endmodule

// File: rtl/bseq_index_gen.sv
module bseq_index_gen
    import burst_seq_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic [COL_W-1:0] base_col_i,
    input  logic [IDX_W-1:0] beat_i,
    input  logic [IDX_W-1:0] mask_i,
    input  order_e           order_i,
    output logic [COL_W-1:0] col_o
);
    logic [IDX_W-1:0] raw_idx;
    logic [COL_W-1:0] wide_mask;

    always_comb begin
        raw_idx   = beat_index(base_col_i[IDX_W-1:0], beat_i, order_i);
        wide_mask = {{(COL_W-IDX_W){1'b0}}, mask_i};
        col_o     = (base_col_i & ~wide_mask)
                  | ({{(COL_W-IDX_W){1'b0}}, raw_idx} & wide_mask);
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned COL_W            = 10,
    parameter bit          RESTART_ON_START = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [1:0]       len_code_i,
    input  logic             order_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    localparam int unsigned HI_W = COL_W - IDX_W;

    typedef struct packed {
        logic [COL_W-1:0] col;
        order_e           ord;
    } burst_cfg_t;

    burst_cfg_t       cfg_q;
    logic [IDX_W-1:0] new_mask;
    logic             new_rsvd;
    logic             load;
    logic             busy;
    logic             at_last;
    logic [IDX_W-1:0] beat;
    logic [IDX_W-1:0] lim;
    logic             err;
    logic [COL_W-1:0] col_w;

    bseq_len_decode u_dec (
        .len_code_i (len_code_i),
        .mask_o     (new_mask),
        .rsvd_o     (new_rsvd)
    );

    bseq_beat_ctrl #(.RESTART_ON_START(RESTART_ON_START)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .rsvd_i  (new_rsvd),
        .mask_i  (new_mask),
        .load_o  (load),
        .busy_o  (busy),
        .last_o  (at_last),
        .beat_o  (beat),
        .lim_o   (lim),
        .err_o   (err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{col: '0, ord: ORD_SEQ};
        end else if (load) begin
            cfg_q <= '{col: start_col_i, ord: order_e'(order_i)};
        end
    end

    bseq_index_gen #(.COL_W(COL_W)) u_idx (
        .base_col_i (cfg_q.col),
        .beat_i     (beat),
        .mask_i     (lim),
        .order_i    (cfg_q.ord),
        .col_o      (col_w)
    );

    assign col_o   = col_w;
    assign valid_o = busy;
    assign last_o  = at_last;
    assign err_o   = err;

    // R2
    upper_block_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !start_i) |=>
            (valid_o && col_o[COL_W-1:IDX_W] == $past(col_o[COL_W-1:HI_W > 0 ? IDX_W : 0])));

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !start_i && cfg_q.ord == ORD_SEQ) |=>
            ((col_o[IDX_W-1:0] & lim) == (($past(col_o[IDX_W-1:0]) + 1'b1) & lim)));

    // R8
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ($past(start_i) && $past(len_code_i) == 2'b00 && !valid_o));
endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [1:0]       len_code_i = 2'b00;
    logic             order_i = 1'b0;
    logic [COL_W-1:0] col_o, rs_col;
    logic             valid_o, last_o, err_o, rs_valid, rs_last, rs_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W), .RESTART_ON_START(1'b0)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .order_i(order_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o));

    burst_col_seq #(.COL_W(COL_W), .RESTART_ON_START(1'b1)) u_rs_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .order_i(order_i),
        .col_o(rs_col), .valid_o(rs_valid), .last_o(rs_last), .err_o(rs_err));

    typedef struct packed {
        logic [1:0]       code;
        logic             ord;
        logic [COL_W-1:0] col;
        logic [3:0]       n;
        logic [23:0]      seq;   // beat k index at [3k+:3]
        logic [COL_W-1:0] base;
    } vec_t;

    localparam vec_t VEC [0:8] = '{
        '{2'b01, 1'b0, 10'h001, 4'd2, 24'o01,       10'h000},  // R1 R3
        '{2'b01, 1'b1, 10'h3FE, 4'd2, 24'o10,       10'h3FE},  // R4
        '{2'b10, 1'b0, 10'h125, 4'd4, 24'o0321,     10'h124},  // R3
        '{2'b10, 1'b1, 10'h0B7, 4'd4, 24'o0123,     10'h0B4},  // R4
        '{2'b11, 1'b1, 10'h2A5, 4'd8, 24'o23016745, 10'h2A0},  // R4
        '{2'b11, 1'b0, 10'h156, 4'd8, 24'o54321076, 10'h150},  // R3
        '{2'b11, 1'b0, 10'h040, 4'd8, 24'o76543210, 10'h040},  // R3
        '{2'b11, 1'b1, 10'h040, 4'd8, 24'o76543210, 10'h040},  // R4
        '{2'b10, 1'b0, 10'h3FF, 4'd4, 24'o2103,     10'h3FC}   // R2
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_beat(input logic [COL_W-1:0] exp, input bit exp_last, input string req);
        check(valid_o && col_o == exp && last_o == exp_last, req, "beat col/valid/last",
              {valid_o, last_o, 20'h0, col_o}, {1'b1, exp_last, 20'h0, exp});
    endtask

    task automatic drive_start(input logic [1:0] code, input logic ord, input logic [COL_W-1:0] col);
        start_i = 1'b1; len_code_i = code; order_i = ord; start_col_i = col;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(!valid_o && !last_o && !err_o, "R9", "reset outputs",
              {valid_o, last_o, err_o}, 0);

        // Vector table: R1 R2 R3 R4 R5
        for (int v = 0; v < 9; v++) begin
            drive_start(VEC[v].code, VEC[v].ord, VEC[v].col);
            @(negedge clk);
            start_i = 1'b0;
            for (int k = 0; k < int'(VEC[v].n); k++) begin
                if (k > 0) @(negedge clk);
                check_beat(VEC[v].base | COL_W'(VEC[v].seq[3*k +: 3]),
                           k == int'(VEC[v].n) - 1, "R1/R2/R3/R4");
            end
            @(negedge clk);
            check(!valid_o && !last_o, "R5", "idle after last", {valid_o, last_o}, 0);
        end

        // R8 reserved code from idle
        drive_start(2'b00, 1'b0, 10'h155);
        @(negedge clk);
        start_i = 1'b0;
        check(err_o && !valid_o, "R8", "err pulse no beat", {err_o, valid_o}, 2'b10);
        @(negedge clk);
        check(!err_o && !valid_o, "R8", "err one cycle", {err_o, valid_o}, 0);

        // R6 back-to-back on final beat
        drive_start(2'b01, 1'b0, 10'h031);
        @(negedge clk);
        start_i = 1'b0;
        check_beat(10'h031, 1'b0, "R6");
        @(negedge clk);
        check_beat(10'h030, 1'b1, "R6");
        drive_start(2'b10, 1'b1, 10'h102);
        @(negedge clk);
        start_i = 1'b0;
        check_beat(10'h102, 1'b0, "R6 no gap");
        @(negedge clk); check_beat(10'h103, 1'b0, "R6");
        @(negedge clk); check_beat(10'h100, 1'b0, "R6");
        @(negedge clk); check_beat(10'h101, 1'b1, "R6");
        @(negedge clk);
        check(!valid_o, "R5", "idle after back-to-back", valid_o, 0);

        // R7 mid-burst start: ignored by u_dut, restarts u_rs_dut
        drive_start(2'b11, 1'b0, 10'h010);
        @(negedge clk);
        start_i = 1'b0;
        check_beat(10'h010, 1'b0, "R7");
        @(negedge clk);
        check_beat(10'h011, 1'b0, "R7");
        drive_start(2'b01, 1'b1, 10'h200);
        @(negedge clk);
        start_i = 1'b0;
        check_beat(10'h012, 1'b0, "R7 ignore");
        check(rs_valid && rs_col == 10'h200 && !rs_last, "R7", "restart beat0",
              {rs_valid, rs_last, rs_col}, {2'b10, 10'h200});
        @(negedge clk);
        check_beat(10'h013, 1'b0, "R7 ignore");
        check(rs_valid && rs_col == 10'h201 && rs_last, "R7", "restart last",
              {rs_valid, rs_last, rs_col}, {2'b11, 10'h201});
        for (int k = 4; k < 8; k++) begin
            @(negedge clk);
            check_beat(10'h010 + COL_W'(k), k == 7, "R7 ignore");
            if (k == 4)
                check(!rs_valid, "R7", "restart burst ended", rs_valid, 0);
        end
        @(negedge clk);
        check(!valid_o, "R5", "idle after ignored start", valid_o, 0);

        // R9 reset mid-burst
        drive_start(2'b11, 1'b1, 10'h0F0);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!valid_o && !last_o && !err_o, "R9", "reset aborts",
              {valid_o, last_o, err_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!valid_o, "R9", "stays idle after reset", valid_o, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule